// File: doc/BRIEF.md
# Prioritized Interrupt Vector Generator

This block collects interrupt requests from three sources: internal exception inputs, non-maskable request lines, and level-sensitive maskable request lines. It chooses one winner and produces the vector number and the 32-bit fetch address of its service routine. Each maskable line has a programmable 3-bit priority level. A maskable line competes only when its level is strictly above the 3-bit core mask. Non-maskable lines and exceptions do not look at the mask.

The fetch address joins three parts, from the most significant bit down: the upper 20 bits of a programmable base register, the 6-bit vector number, and six zero bits. Every routine therefore owns a 64-byte slot. Taking a vector gives a one-cycle valid pulse. The mask is then raised to the winner's level, or to 7 for a non-maskable line. The block presents nothing more until the core returns an acknowledge.

When the vector-disabled mode is set, non-maskable and maskable winners collapse onto two fixed default vectors. Software programs the base, the levels, the mask and the mode through a simple write port.

Top module: `ivg_vector_gen`

## Requirements
- R1: A maskable line is accepted only if it is asserted and its level is strictly greater than the current mask. A level equal to the mask is not accepted.
- R2: After reset the mask reads 3'b111, and no valid pulse is produced.
- R3: The fetch address is {base[31:12], vector[5:0], 6'b000000}. The base is written at register address 0 from write data bits 31:12.
- R4: The mask is written at register address 1 from data bits 2:0. The mode is written at address 2 from data bit 0, where 1 selects vector-disabled mode. The level of maskable line i is written at address 32+i from data bits 2:0.
- R5: In normal mode, maskable line i produces vector 0x20+i, so line 23 gives 0x37.
- R6: A maskable line whose level is 0 is never accepted, even when the mask is 0.
- R7: Among accepted maskable lines, the highest level wins. If levels tie, the lowest line index wins.
- R8: A non-maskable line is accepted whatever the mask holds, and it beats any maskable line. Line k gives vector 0x38+k in normal mode. Among non-maskable lines the lowest index wins.
- R9: When a vector is taken from a maskable line, the mask becomes that line's level. When it is taken from a non-maskable line, the mask becomes 7. An exception leaves the mask unchanged.
- R10: Exception inputs beat all external requests. Input bit 0 (trap) gives vector 0x0, bit 1 (illegal instruction) gives 0x2, bit 2 (debug) gives 0x3 and bit 3 (overflow) gives 0x4. Among exceptions the lowest bit wins.
- R11: In vector-disabled mode, an accepted non-maskable line gives vector 0x6 and an accepted maskable line gives vector 0x7. Exceptions keep their own vectors.
- R12: The valid output is high for exactly one cycle per vector taken. No further vector is presented until the acknowledge input is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 24 | Level-sensitive maskable request lines |
| nmi_req | input | 8 | Non-maskable request lines |
| exc_req | input | 4 | Exception inputs: trap, illegal, debug, overflow |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register write address |
| cfg_wdata | input | 32 | Register write data |
| vec_ack | input | 1 | Acknowledge from the core; allows the next vector |
| vec_valid | output | 1 | One-cycle pulse when a vector is taken |
| vec_num | output | 6 | Vector number of the taken request |
| vec_addr | output | 32 | Service-routine fetch address |
| cur_mask | output | 3 | Current core mask |

## Verification
The hardest case to reach is a request that is pending and would win, but that must stay silent. One form is a line held at a level exactly equal to the raised mask. The other is a higher-level line that arrives while the block waits for the acknowledge. The stimulus takes a first vector, keeps its line asserted, and then either acknowledges it or raises a second line. In the first case the block must stay silent after the acknowledge. In the second it must stay silent until the acknowledge and then fire the new vector.

// File: rtl/ivg_pkg.sv
package ivg_pkg;
  typedef enum logic {ST_IDLE, ST_WAIT} ivg_state_e;

  localparam int VEC_W   = 6;
  localparam int SLOT_W  = 6;
  localparam int EXC_N   = 4;
  localparam int CFG_AW  = 6;

  localparam int REG_BASE = 0;
  localparam int REG_MASK = 1;
  localparam int REG_MODE = 2;
  localparam int REG_LVL0 = 32;

  localparam logic [VEC_W-1:0] V_DFLT_NMI = 6'h06;
  localparam logic [VEC_W-1:0] V_DFLT_IRQ = 6'h07;
  localparam int               V_IRQ0     = 32;

  function automatic logic [VEC_W-1:0] exc_vector(input int idx);
    case (idx)
      0:       exc_vector = 6'h00;
      1:       exc_vector = 6'h02;
      2:       exc_vector = 6'h03;
      default: exc_vector = 6'h04;
    endcase
  endfunction
endpackage

// File: rtl/ivg_cfg_regs.sv
module ivg_cfg_regs
  import ivg_pkg::*;
#(
  parameter int N_IRQ  = 24,
  parameter int LVL_W  = 3,
  parameter int ADDR_W = 32,
  localparam int BASE_W = ADDR_W - VEC_W - SLOT_W
)(
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we,
  input  logic [CFG_AW-1:0]           addr,
  input  logic [ADDR_W-1:0]           wdata,
  input  logic                        take_set,
  input  logic [LVL_W-1:0]            take_mask,
  output logic [BASE_W-1:0]           base_q,
  output logic [LVL_W-1:0]            mask_q,
  output logic                        mode_q,
  output logic [N_IRQ-1:0][LVL_W-1:0] lvl_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      mask_q <= '1;
      mode_q <= 1'b0;
    end else begin
      if (we && addr == CFG_AW'(REG_BASE)) base_q <= wdata[ADDR_W-1 -: BASE_W];
      if (we && addr == CFG_AW'(REG_MODE)) mode_q <= wdata[0];
      if (take_set)
        mask_q <= take_mask;
      else if (we && addr == CFG_AW'(REG_MASK))
        mask_q <= wdata[LVL_W-1:0];
    end
  end

  for (genvar gi = 0; gi < N_IRQ; gi++) begin : g_lvl
    always_ff @(posedge clk) begin
      if (rst)
        lvl_q[gi] <= '0;
      else if (we && addr == CFG_AW'(REG_LVL0 + gi))
        lvl_q[gi] <= wdata[LVL_W-1:0];
    end
  end
endmodule

// File: rtl/ivg_select.sv
module ivg_select
  import ivg_pkg::*;
#(
  parameter int N_IRQ = 24,
  parameter int N_NMI = 8,
  parameter int LVL_W = 3,
  localparam int IRQ_IW = $clog2(N_IRQ),
  localparam int NMI_IW = $clog2(N_NMI),
  localparam int V_NMI0 = V_IRQ0 + N_IRQ
)(
  input  logic                        clk,
  input  logic                        rst,
  input  logic [N_IRQ-1:0]            irq,
  input  logic [N_NMI-1:0]            nmi,
  input  logic [EXC_N-1:0]            exc,
  input  logic [N_IRQ-1:0][LVL_W-1:0] lvl,
  input  logic [LVL_W-1:0]            mask,
  input  logic                        vec_off,
  output logic                        hit,
  output logic [VEC_W-1:0]            vec,
  output logic                        set_mask,
  output logic [LVL_W-1:0]            new_mask
);
  logic [N_IRQ-1:0]  acc;
  logic              irq_hit, nmi_hit, exc_hit;
  logic [IRQ_IW-1:0] irq_idx;
  logic [LVL_W-1:0]  irq_lvl;
  logic [NMI_IW-1:0] nmi_idx;
  logic [VEC_W-1:0]  exc_v;

  for (genvar gi = 0; gi < N_IRQ; gi++) begin : g_acc
    assign acc[gi] = irq[gi] && (lvl[gi] != '0) && (lvl[gi] > mask);
  end

  always_comb begin
    irq_hit = 1'b0;
    irq_idx = '0;
    irq_lvl = '0;
    for (int i = 0; i < N_IRQ; i++) begin
      if (acc[i] && (!irq_hit || lvl[i] > irq_lvl)) begin
        irq_hit = 1'b1;
        irq_idx = IRQ_IW'(i);
        irq_lvl = lvl[i];
      end
    end
  end

  always_comb begin
    nmi_hit = 1'b0;
    nmi_idx = '0;
    for (int i = 0; i < N_NMI; i++) begin
      if (nmi[i] && !nmi_hit) begin
        nmi_hit = 1'b1;
        nmi_idx = NMI_IW'(i);
      end
    end
  end

  always_comb begin
    exc_hit = 1'b0;
    exc_v   = '0;
    for (int i = 0; i < EXC_N; i++) begin
      if (exc[i] && !exc_hit) begin
        exc_hit = 1'b1;
        exc_v   = exc_vector(i);
      end
    end
  end

  always_comb begin
    hit      = exc_hit || nmi_hit || irq_hit;
    vec      = '0;
    set_mask = 1'b0;
    new_mask = mask;
    if (exc_hit) begin
      vec = exc_v;
    end else if (nmi_hit) begin
      vec      = vec_off ? V_DFLT_NMI : VEC_W'(V_NMI0 + int'(nmi_idx));
      set_mask = 1'b1;
      new_mask = '1;
    end else if (irq_hit) begin
      vec      = vec_off ? V_DFLT_IRQ : VEC_W'(V_IRQ0 + int'(irq_idx));
      set_mask = 1'b1;
      new_mask = irq_lvl;
    end
  end

  // R1
  irq_above_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && !exc_hit && !nmi_hit) |-> (new_mask > mask));

  // R8
  nmi_mask_full_chk: assert property (@(posedge clk) disable iff (rst)
    (|nmi && !(|exc)) |-> (set_mask && new_mask == '1));
endmodule

// File: rtl/ivg_vector_gen.sv
module ivg_vector_gen
  import ivg_pkg::*;
#(
  parameter int N_IRQ  = 24,
  parameter int N_NMI  = 8,
  parameter int LVL_W  = 3,
  parameter int ADDR_W = 32,
  localparam int BASE_W = ADDR_W - VEC_W - SLOT_W
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [N_IRQ-1:0]  irq_req,
  input  logic [N_NMI-1:0]  nmi_req,
  input  logic [EXC_N-1:0]  exc_req,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              vec_ack,
  output logic              vec_valid,
  output logic [VEC_W-1:0]  vec_num,
  output logic [ADDR_W-1:0] vec_addr,
  output logic [LVL_W-1:0]  cur_mask
);
  logic [BASE_W-1:0]           base_q;
  logic [LVL_W-1:0]            mask_q;
  logic                        mode_q;
  logic [N_IRQ-1:0][LVL_W-1:0] lvl_q;
  logic                        sel_hit, sel_set;
  logic [VEC_W-1:0]            sel_vec;
  logic [LVL_W-1:0]            sel_mask;
  logic                        take;
  ivg_state_e                  state_q;

  assign take = (state_q == ST_IDLE) && sel_hit;

  ivg_cfg_regs #(.N_IRQ(N_IRQ), .LVL_W(LVL_W), .ADDR_W(ADDR_W)) i_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .take_set(take && sel_set), .take_mask(sel_mask),
    .base_q(base_q), .mask_q(mask_q), .mode_q(mode_q), .lvl_q(lvl_q)
  );

  ivg_select #(.N_IRQ(N_IRQ), .N_NMI(N_NMI), .LVL_W(LVL_W)) i_sel (
    .clk(clk), .rst(rst), .irq(irq_req), .nmi(nmi_req), .exc(exc_req),
    .lvl(lvl_q), .mask(mask_q), .vec_off(mode_q),
    .hit(sel_hit), .vec(sel_vec), .set_mask(sel_set), .new_mask(sel_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      vec_valid <= 1'b0;
      vec_num   <= '0;
      vec_addr  <= '0;
    end else begin
      vec_valid <= take;
      if (take) begin
        state_q  <= ST_WAIT;
        vec_num  <= sel_vec;
        vec_addr <= {base_q, sel_vec, {SLOT_W{1'b0}}};
      end else if (state_q == ST_WAIT && vec_ack) begin
        state_q <= ST_IDLE;
      end
    end
  end

  assign cur_mask = mask_q;

  // R12
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    vec_valid |=> !vec_valid);

  // R12
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && !vec_ack) |=> !vec_valid);

  // R9
  mask_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (take && sel_set) |=> (mask_q == $past(sel_mask)));

  // R11
  vec_off_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_valid && mode_q) |-> (vec_num <= 6'h07 && vec_num != 6'h01 && vec_num != 6'h05));

  // R3
  slot_align_chk: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> (vec_addr[SLOT_W-1:0] == '0));
endmodule

// File: tb/test_ivg_vector_gen.sv
module test_ivg_vector_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] irq_req = '0;
  logic [7:0]  nmi_req = '0;
  logic [3:0]  exc_req = '0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        vec_ack = 1'b0;
  logic        vec_valid;
  logic [5:0]  vec_num;
  logic [31:0] vec_addr;
  logic [2:0]  cur_mask;

  always #2.5 clk = ~clk;

  ivg_vector_gen i_ivg_vector_gen (
    .clk(clk), .rst(rst), .irq_req(irq_req), .nmi_req(nmi_req), .exc_req(exc_req),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .vec_ack(vec_ack),
    .vec_valid(vec_valid), .vec_num(vec_num), .vec_addr(vec_addr), .cur_mask(cur_mask)
  );

  typedef struct {
    logic [5:0]  vec;
    logic [31:0] addr;
    logic [2:0]  mask;
    string       req;
  } exp_t;

  exp_t        exp_q[$];
  int          n_tests = 0;
  int          n_fail  = 0;
  int          pulses  = 0;
  logic [31:0] base    = 32'hABCDE000;

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && vec_valid) begin
      pulses++;
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected pulse (R1/R12): vec=%h expected none", vec_num);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (vec_num !== e.vec || vec_addr !== e.addr || cur_mask !== e.mask) begin
          n_fail++;
          $display("FAIL %s: vec=%h addr=%h mask=%0d expected vec=%h addr=%h mask=%0d",
                   e.req, vec_num, vec_addr, cur_mask, e.vec, e.addr, e.mask);
        end
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 6'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic push(input logic [5:0] v, input logic [2:0] m, input string req);
    exp_t e;
    e.vec = v; e.addr = {base[31:12], v, 6'b0}; e.mask = m; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic wait_pulse(input int p0, input string req);
    int n = 0;
    while (pulses == p0 && n < 40) begin
      @(negedge clk); #1;
      n++;
    end
    if (pulses == p0) begin
      n_tests++; n_fail++;
      $display("FAIL %s: no pulse, expected one", req);
    end
  endtask

  task automatic no_pulse(input int cycles, input string req);
    int p0 = pulses;
    repeat (cycles) @(negedge clk);
    #1;
    check(req, pulses, p0);
  endtask

  task automatic ack;
    @(negedge clk); vec_ack = 1'b1;
    @(negedge clk); vec_ack = 1'b0;
  endtask

  task automatic release_ack;
    @(negedge clk);
    irq_req = '0; nmi_req = '0; exc_req = '0;
    ack();
  endtask

  task automatic fire(input logic [23:0] i, input logic [7:0] n, input logic [3:0] x,
                      input logic [5:0] v, input logic [2:0] m, input string req);
    int p0 = pulses;
    push(v, m, req);
    @(negedge clk);
    irq_req = i; nmi_req = n; exc_req = x;
    wait_pulse(p0, req);
    release_ack();
  endtask

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    // R2 reset state
    check("R2 mask", 32'(cur_mask), 32'h7);
    check("R2 valid", 32'(vec_valid), 32'h0);

    wr(0, base);                                   // R3 base
    wr(32 + 3, 32'd5);                             // R4 level of line 3
    // R1 blocked by reset mask
    @(negedge clk); irq_req[3] = 1'b1;
    no_pulse(20, "R1 mask 7 blocks");
    // R1 R3 R5 R9 mask lowered to 4 -> line 3 accepted
    p0 = pulses;
    push(6'h23, 3'd5, "R1 R3 R5 R9 line3");
    wr(1, 32'd4);
    wait_pulse(p0, "R1 line3");
    ack();
    // R1 level equal to mask (5) is not accepted
    no_pulse(20, "R1 strict greater");
    release_ack();

    // R6 level zero never accepted
    wr(1, 32'd0);
    @(negedge clk); irq_req[10] = 1'b1;
    no_pulse(20, "R6 level zero");
    @(negedge clk); irq_req = '0;

    // R7 tie -> lowest index
    wr(32 + 2, 32'd4);
    wr(32 + 7, 32'd4);
    fire(24'h000084, 8'h00, 4'h0, 6'h22, 3'd4, "R7 tie");
    // R7 higher level wins
    wr(32 + 9, 32'd6);
    wr(32 + 1, 32'd3);
    wr(1, 32'd0);
    fire(24'h000202, 8'h00, 4'h0, 6'h29, 3'd6, "R7 higher level");
    // R5 last line
    wr(32 + 23, 32'd7);
    wr(1, 32'd0);
    fire(24'h800000, 8'h00, 4'h0, 6'h37, 3'd7, "R5 line23");

    // R8 non-maskable ignores mask 7
    wr(1, 32'd7);
    fire(24'h000000, 8'h20, 4'h0, 6'h3D, 3'd7, "R8 nmi5 mask7");
    wr(1, 32'd0);
    fire(24'h800000, 8'h84, 4'h0, 6'h3A, 3'd7, "R8 nmi beats irq");

    // R10 exceptions, mask unchanged (R9)
    wr(1, 32'd3);
    fire(24'h800000, 8'h08, 4'h1, 6'h00, 3'd3, "R10 trap");
    fire(24'h000000, 8'h00, 4'hA, 6'h02, 3'd3, "R10 illegal");
    fire(24'h000000, 8'h00, 4'h4, 6'h03, 3'd3, "R10 debug");
    fire(24'h000000, 8'h00, 4'h8, 6'h04, 3'd3, "R10 overflow");

    // R11 vector-disabled mode
    wr(2, 32'd1);
    wr(1, 32'd7);
    fire(24'h000000, 8'h01, 4'h0, 6'h06, 3'd7, "R11 default nmi");
    wr(1, 32'd0);
    fire(24'h000004, 8'h00, 4'h0, 6'h07, 3'd4, "R11 default irq");
    fire(24'h000000, 8'h00, 4'h8, 6'h04, 3'd4, "R11 exception kept");
    wr(2, 32'd0);

    // R12 no second vector before ack
    wr(32 + 4, 32'd2);
    wr(32 + 5, 32'd6);
    wr(1, 32'd0);
    p0 = pulses;
    push(6'h24, 3'd2, "R12 first");
    @(negedge clk); irq_req[4] = 1'b1;
    wait_pulse(p0, "R12 first");
    @(negedge clk); irq_req[5] = 1'b1;
    no_pulse(10, "R12 held until ack");
    p0 = pulses;
    push(6'h25, 3'd6, "R12 after ack");
    ack();
    wait_pulse(p0, "R12 after ack");
    release_ack();

    repeat (5) @(negedge clk);
    check("R12 queue drained", 32'(exp_q.size()), 32'h0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule